// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Status

This block is the holding stage between a serial frame receiver and the register read port that software uses to collect received characters. Each time the receiver finishes a frame it offers a 9-bit character with its frame-error and parity-error indications. The queue keeps up to two such characters in arrival order. Every slot carries its own error bits and its own overrun mark, so the status that software reads always describes the character that will be returned next.

Software reads in a fixed order. It reads the status register and the ninth-bit register first, and neither read changes anything. It then reads the low data byte, and that read removes the character. A level flag reports that unread data is waiting, and a level interrupt follows that flag when the interrupt enable is set. A third character arriving with both slots full and no read in the same cycle is lost. The newest stored character is then marked, and every further character is dropped until software reads a data byte. Clearing the receive enable empties the queue at once.

Top module: `rx_char_queue`

## Requirements
- R1: The queue stores up to two characters and returns them in the order they arrived. A write accepted with one slot free makes both slots occupied.
- R2: Each slot keeps the full 9 data bits and its own flags. The status read data places frame error at bit 2, overrun at bit 1 and parity error at bit 0, and it always describes the oldest unread character.
- R3: Read data is valid in the same cycle as its strobe. A status or ninth-bit read leaves the queue unchanged. A low-byte read returns data bits 7:0 of the oldest character and removes that character.
- R4: `rx_done` is 1 exactly when at least one unread character is held, and 0 when the queue is empty.
- R5: While `rx_en` is 0, the queue empties on the next clock edge and `rx_done` goes to 0. Characters offered while disabled are not stored.
- R6: `rx_irq` is a level equal to `rx_done` AND `irq_en` in every cycle.
- R7: A write that arrives with both slots full and no low-byte read in the same cycle is discarded. It sets the overrun bit of the newest stored character, and that bit shows in the status once the character reaches the head.
- R8: After an overrun, every offered character is dropped until the next low-byte read. That read ends the dropping state, so a character offered in the same cycle as the read, or later, is stored.
- R9: With the queue empty, all three read data outputs are 0, and reads change neither the count nor any flag.
- R10: A write and a low-byte read in the same cycle on a full queue store the new character without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; 0 empties the queue |
| irq_en | input | 1 | Receive-complete interrupt enable |
| wr_valid | input | 1 | Receiver offers a completed character this cycle |
| wr_data | input | 9 | Received character |
| wr_frame_err | input | 1 | Stop bit of that character was 0 |
| wr_parity_err | input | 1 | Parity mismatch on that character |
| rd_status | input | 1 | Status register read strobe |
| rd_bit8 | input | 1 | Ninth-bit register read strobe |
| rd_low | input | 1 | Low data byte read strobe; removes the head character |
| rx_done | output | 1 | Unread data present |
| rx_irq | output | 1 | Receive interrupt level |
| status_rdata | output | 3 | {frame error, overrun, parity error} of head when rd_status, else 0 |
| bit8_rdata | output | 1 | Bit 8 of head character when rd_bit8, else 0 |
| low_rdata | output | 8 | Bits 7:0 of head character when rd_low, else 0 |

## Verification
A wrong count or pointer shows on the very next read. A second character may be returned first. A stale character may reappear. `rx_done` may stay high after the last read, or drop while a character is still held. An overrun mark placed in the wrong slot shows in the status read one character early or late. A dropping state that ends too soon or too late shows as one character too many or too few, at the first low-byte read after the overrun. Every one of these is observable within one or two reads of the event that caused it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned CHAR_W = 9;
  localparam int unsigned LOW_W  = 8;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } slot_t;

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned wrap_dec(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic          mark_ovr,
  input  rxq_pkg::slot_t din,
  output rxq_pkg::slot_t head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  rxq_pkg::slot_t slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [PW-1:0] newest;

  assign newest = PW'(rxq_pkg::wrap_dec(32'(wr_ptr), DEPTH));
  assign head   = slots[rd_ptr];
  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) slots[i] <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (mark_ovr) slots[newest].ovr <= 1'b1;
      if (push) begin
        slots[wr_ptr] <= din;
        wr_ptr <= PW'(rxq_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      end
      if (pop) rd_ptr <= PW'(rxq_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      if (push && !pop) count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> count == $past(count) + CW'(1));
  assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush) |=> count == $past(count) - CW'(1));
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic wr_valid,
  input  logic rd_low,
  input  logic full,
  input  logic empty,
  output logic flush,
  output logic push,
  output logic pop,
  output logic mark_ovr,
  output logic discard
);
  logic offered;

  assign flush    = !rx_en;
  assign offered  = wr_valid && rx_en;
  assign pop      = rd_low && rx_en && !empty;
  assign push     = offered && (!discard || pop) && (!full || pop);
  assign mark_ovr = offered && !discard && full && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        discard <= 1'b0;
    else if (flush)    discard <= 1'b0;
    else if (pop)      discard <= 1'b0;
    else if (mark_ovr) discard <= 1'b1;
  end

  assert_ovr_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mark_ovr |-> (full && !push));
  assert_drop_after_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !pop) |-> !push);
  assert_read_ends_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !discard);
  assert_same_cycle_rw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rx_en && full && pop) |-> (push && !mark_ovr));
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int unsigned DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       irq_en,
  input  logic       wr_valid,
  input  logic [8:0] wr_data,
  input  logic       wr_frame_err,
  input  logic       wr_parity_err,
  input  logic       rd_status,
  input  logic       rd_bit8,
  input  logic       rd_low,
  output logic       rx_done,
  output logic       rx_irq,
  output logic [2:0] status_rdata,
  output logic       bit8_rdata,
  output logic [7:0] low_rdata
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rxq_pkg::slot_t din, head;
  logic [CW-1:0]  count;
  logic full, empty, flush, push, pop, mark_ovr, discard;

  assign din = '{ovr: 1'b0, fe: wr_frame_err, pe: wr_parity_err, data: wr_data};

  rxq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid), .rd_low(rd_low),
    .full(full), .empty(empty), .flush(flush), .push(push), .pop(pop),
    .mark_ovr(mark_ovr), .discard(discard)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .mark_ovr(mark_ovr), .din(din), .head(head), .count(count),
    .full(full), .empty(empty)
  );

  assign rx_done      = !empty;
  assign rx_irq       = rx_done && irq_en;
  assign status_rdata = (rd_status && !empty) ? {head.fe, head.ovr, head.pe} : 3'b000;
  assign bit8_rdata   = rd_bit8 && !empty && head.data[rxq_pkg::CHAR_W-1];
  assign low_rdata    = (rd_low && !empty) ? head.data[rxq_pkg::LOW_W-1:0] : '0;

  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> (status_rdata == 3'b000 && !bit8_rdata && low_rdata == '0));
  assert_done_tracks_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done == (count != '0));
  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_done);
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !rx_irq);
  assert_side_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rd_low && !wr_valid) |=> $stable(count));
  assert_discard_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> full);
endmodule

// File: tb/tb_rx_char_queue.sv
module tb_rx_char_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, irq_en = 1'b0, wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic wr_frame_err = 1'b0, wr_parity_err = 1'b0;
  logic rd_status = 1'b0, rd_bit8 = 1'b0, rd_low = 1'b0;
  logic rx_done, rx_irq, bit8_rdata;
  logic [2:0] status_rdata;
  logic [7:0] low_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model: index 0 is the oldest character
  logic [8:0] m_data [2];
  logic m_fe [2], m_pe [2], m_ovr [2];
  int m_cnt = 0;
  bit m_drop = 0;

  always #4 clk = ~clk;

  rx_char_queue dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_en(irq_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_frame_err(wr_frame_err), .wr_parity_err(wr_parity_err),
    .rd_status(rd_status), .rd_bit8(rd_bit8), .rd_low(rd_low),
    .rx_done(rx_done), .rx_irq(rx_irq), .status_rdata(status_rdata),
    .bit8_rdata(bit8_rdata), .low_rdata(low_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_status(input bit rs);
    if (!rs || m_cnt == 0) return 0;
    return {m_fe[0], m_ovr[0], m_pe[0]};
  endfunction

  function automatic int exp_low(input bit rl);
    if (!rl || m_cnt == 0) return 0;
    return m_data[0][7:0];
  endfunction

  task automatic model_update(input bit wv, input logic [8:0] wd, input bit fe, input bit pe,
                              input bit en, input bit rl);
    bit pop, ovr, drop;
    int pre;
    if (!en) begin
      m_cnt = 0;
      m_drop = 0;
      return;
    end
    pre  = m_cnt;
    pop  = rl && pre > 0;
    ovr  = wv && !m_drop && pre == 2 && !pop;
    drop = wv && m_drop && !pop;
    if (ovr) begin
      m_ovr[1] = 1'b1;
      m_drop = 1;
    end
    if (pop) begin
      m_data[0] = m_data[1]; m_fe[0] = m_fe[1]; m_pe[0] = m_pe[1]; m_ovr[0] = m_ovr[1];
      m_cnt--;
      m_drop = 0;
    end
    if (wv && !ovr && !drop) begin
      m_data[m_cnt] = wd; m_fe[m_cnt] = fe; m_pe[m_cnt] = pe; m_ovr[m_cnt] = 1'b0;
      m_cnt++;
    end
  endtask

  task automatic step(input bit wv, input logic [8:0] wd, input bit fe, input bit pe,
                      input bit en, input bit ie, input bit rs, input bit rb, input bit rl,
                      input string tag);
    @(negedge clk);
    wr_valid = wv; wr_data = wd; wr_frame_err = fe; wr_parity_err = pe;
    rx_en = en; irq_en = ie; rd_status = rs; rd_bit8 = rb; rd_low = rl;
    #1;
    check({"R4 rx_done ", tag}, int'(rx_done), int'(m_cnt != 0));
    check({"R6 rx_irq ", tag}, int'(rx_irq), int'(m_cnt != 0 && ie));
    check({"R2 R7 status ", tag}, int'(status_rdata), exp_status(rs));
    check({"R3 R9 bit8 ", tag}, int'(bit8_rdata), int'(rb && m_cnt != 0 && m_data[0][8]));
    check({"R3 R9 low ", tag}, int'(low_rdata), exp_low(rl));
    @(posedge clk);
    model_update(wv, wd, fe, pe, en, rl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_data[i] = '0; m_fe[i] = 0; m_pe[i] = 0; m_ovr[i] = 0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R4 reset rx_done", int'(rx_done), 0);
    check("R6 reset rx_irq", int'(rx_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reads on an empty queue
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 1, "R9 empty");
    step(0, 9'h000, 0, 0, 1, 1, 0, 0, 0, "R9 after");
    // R1 R2: fill with flagged characters
    step(1, 9'h1A5, 1, 0, 1, 1, 0, 0, 0, "R1 first");
    step(1, 9'h03C, 0, 1, 1, 1, 1, 1, 0, "R1 second");
    // R7: third arrives full, R8: fourth dropped
    step(1, 9'h0FF, 0, 0, 1, 1, 1, 1, 0, "R7 overrun");
    step(1, 9'h111, 0, 0, 1, 1, 1, 1, 0, "R8 dropped");
    step(0, 9'h000, 0, 0, 1, 0, 1, 1, 1, "R3 pop first");
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 0, "R7 ovr at head");
    step(1, 9'h122, 0, 0, 1, 1, 0, 0, 0, "R8 accepted");
    // R10: simultaneous write and read on full queue
    step(1, 9'h155, 1, 1, 1, 1, 1, 0, 1, "R10 rw full");
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 1, "R10 read");
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 1, "R10 read2");
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 1, "R9 empty again");
    // R8: read ends dropping in same cycle as write
    step(1, 9'h001, 0, 0, 1, 1, 0, 0, 0, "R8 a");
    step(1, 9'h002, 0, 0, 1, 1, 0, 0, 0, "R8 b");
    step(1, 9'h003, 0, 0, 1, 1, 0, 0, 0, "R8 ovr");
    step(1, 9'h104, 0, 0, 1, 1, 1, 1, 1, "R8 rw");
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 1, "R8 check");
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 1, "R8 check2");
    // R5: disable flushes and blocks writes
    step(1, 9'h0AA, 0, 0, 1, 1, 0, 0, 0, "R5 load");
    step(1, 9'h0BB, 0, 0, 0, 1, 0, 0, 0, "R5 disable");
    step(1, 9'h0CC, 0, 0, 0, 1, 1, 1, 1, "R5 disabled");
    step(0, 9'h000, 0, 0, 1, 1, 1, 1, 1, "R5 after");

    for (int n = 0; n < 4000; n++) begin
      bit en;
      en = ($urandom % 16) != 0;
      step(($urandom % 2) == 1, 9'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
           en, ($urandom % 2) == 1, ($urandom % 2) == 1, ($urandom % 2) == 1,
           ($urandom % 10) < 3, "R1 R7 R8 R10 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule